// File: doc/BRIEF.md
# Keypad Matrix Scan Controller

This block scans a key matrix of up to sixteen rows by sixteen columns on behalf of a processor. It pulls one row line low at a time, waits a programmable settling time, captures the column lines and keeps one halfword per row in a bank of readable registers. Keys are active-low: a released key reads as 1 and a pressed key on the driven row reads as 0.

Software picks one of four operating modes through the control register. Idle leaves every row released. Any-key detection pulls all rows low at once and raises a status flag while any column is low. Single scan runs through the rows once and then clears its own mode field. Continuous scan repeats after a programmable gap. A configuration register limits how many rows are visited and how many column bits are kept. Three sticky status flags (scan finished, stored data changed, key seen in any-key mode) each have a mask bit and combine into one interrupt line.

Top module: `kpd_scan_top`

## Requirements
- R1: After reset the control word, status and mask read 0, the configuration reads 0x1010 (16 columns, 16 rows), every row register reads 0xFFFF, all row lines are high and `irq` is low.
- R2: The control register at byte offset 0x00 holds the mode in bits 1:0 (0 idle, 1 any-key, 2 single scan, 3 continuous), the per-row settle count in bits 15:2 and the between-scan gap in bits 31:16, and reads back as written.
- R3: During a scan exactly one row line is low at a time, in ascending order from row 0; row r stays low for settle+1 cycles and the columns are captured in the last of those cycles.
- R4: In single-scan mode one cycle after the last row the scan completes, the mode field returns to 0 by itself and all row lines go high.
- R5: In continuous mode the completion cycle is followed by gap+1 cycles with no row low, after which row 0 is driven again.
- R6: In any-key mode all row lines are low, the row registers are not written, and status bit 2 is set in every cycle in which any column is low; a write-one to bit 2 does not clear it while a key is held.
- R7: Configuration bits 7:0 give the row count (values above 16 act as 16); rows at or above it are neither driven nor updated and keep their earlier contents.
- R8: Configuration bits 15:8 give the column count; column bits at or above it are stored as 1 whenever a row is updated.
- R9: Status at offset 0x08 sets bit 0 at every scan completion and bit 1 at a completion where any stored row value changed during that scan; writing 1 to a bit clears it, and a set in the same cycle wins over the clear.
- R10: The mask at offset 0x0C enables each status bit; `irq` is high one cycle after any status bit is set together with its mask bit.
- R11: Offset 0x10+4k reads row 2k in bits 15:0 and row 2k+1 in bits 31:16; the configuration at 0x04 is in bits 15:0; reads return data one cycle after the request.
- R12: Any write of the control register aborts a scan in progress, discards it without setting status, and restarts from row 0 if the new mode is a scanning mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| row_drive_n | output | 16 | Row lines, low means the row is driven |
| col_in_n | input | 16 | Column lines, low means a pressed key on a driven row |
| irq | output | 1 | Masked interrupt request |

## Verification
A sequencer whose row or delay counter slips shows up on `row_drive_n` in the very cycle it goes wrong, since the bench's model predicts the row lines and `irq` on every clock. A wrong column mask, a stray write in any-key mode or a missed change flag only shows at the next register read, so the bench reads every row register and the status after each scan pattern. Abort behaviour is checked by rewriting the control word mid-scan, after which row 0 must be low on the very next cycle.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_ANYKEY = 2'd1,
    MODE_SINGLE = 2'd2,
    MODE_CONT   = 2'd3
  } kpd_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SCAN = 2'd1,
    SQ_GAP  = 2'd2
  } kpd_seq_e;

  // word indices (byte address / 4)
  localparam int unsigned WA_CTRL = 0;
  localparam int unsigned WA_CFG  = 1;
  localparam int unsigned WA_STAT = 2;
  localparam int unsigned WA_MASK = 3;
  localparam int unsigned WA_DATA = 4;

  localparam int unsigned SETTLE_W = 14;
  localparam int unsigned GAP_W    = 16;
  localparam int unsigned NSRC     = 3;
endpackage

// File: rtl/kpd_regs.sv
module kpd_regs import kpd_pkg::*; #(
  parameter int NROW = 16,
  parameter int NCOL = 16,
  parameter int AW   = 6,
  localparam int RW     = $clog2(NROW + 1),
  localparam int NWORDS = (NROW + 1) / 2,
  localparam int WIW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [31:0]         bus_wdata,
  input  logic                scan_done,
  input  logic                scan_chg,
  input  logic                key_seen,
  input  logic [31:0]         data_pair,
  output logic [1:0]          mode,
  output logic [SETTLE_W-1:0] settle,
  output logic [GAP_W-1:0]    gap,
  output logic [RW-1:0]       eff_rows,
  output logic [NCOL-1:0]     col_keep,
  output logic                ctl_wr,
  output logic [WIW-1:0]      rd_word,
  output logic [NSRC-1:0]     stat,
  output logic [NSRC-1:0]     mask,
  output logic [31:0]         rdata,
  output logic                irq
);
  logic [31:0]     ctrl_q;
  logic [15:0]     cfg_q;
  logic [NSRC-1:0] stat_q, mask_q, stat_set, stat_clr;
  logic [AW-3:0]   wa;
  logic            cfg_wr, stat_wr, mask_wr, rd_en;
  logic [31:0]     rd_mux;
  logic [1:0]      unused_addr_lsb;

  assign unused_addr_lsb = bus_addr[1:0];
  assign wa      = bus_addr[AW-1:2];
  assign ctl_wr  = bus_sel & bus_wr & (wa == (AW-2)'(WA_CTRL));
  assign cfg_wr  = bus_sel & bus_wr & (wa == (AW-2)'(WA_CFG));
  assign stat_wr = bus_sel & bus_wr & (wa == (AW-2)'(WA_STAT));
  assign mask_wr = bus_sel & bus_wr & (wa == (AW-2)'(WA_MASK));
  assign rd_en   = bus_sel & ~bus_wr;

  assign mode   = ctrl_q[1:0];
  assign settle = ctrl_q[SETTLE_W+1:2];
  assign gap    = ctrl_q[31:16];
  assign stat   = stat_q;
  assign mask   = mask_q;

  assign eff_rows = (cfg_q[7:0] > 8'(NROW)) ? RW'(NROW) : RW'(cfg_q[7:0]);

  for (genvar c = 0; c < NCOL; c++) begin : g_keep
    assign col_keep[c] = (8'(c) < cfg_q[15:8]);
  end

  assign rd_word  = WIW'(wa - (AW-2)'(WA_DATA));
  assign stat_set = {key_seen, scan_done & scan_chg, scan_done};
  assign stat_clr = stat_wr ? bus_wdata[NSRC-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    if (wa == (AW-2)'(WA_CTRL))      rd_mux = ctrl_q;
    else if (wa == (AW-2)'(WA_CFG))  rd_mux = {16'h0, cfg_q};
    else if (wa == (AW-2)'(WA_STAT)) rd_mux = {{(32-NSRC){1'b0}}, stat_q};
    else if (wa == (AW-2)'(WA_MASK)) rd_mux = {{(32-NSRC){1'b0}}, mask_q};
    else if (int'(wa) >= WA_DATA && int'(wa) < WA_DATA + NWORDS) rd_mux = data_pair;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cfg_q  <= {8'(NCOL), 8'(NROW)};
      stat_q <= '0;
      mask_q <= '0;
      rdata  <= '0;
      irq    <= 1'b0;
    end else begin
      if (ctl_wr)
        ctrl_q <= bus_wdata;
      else if (scan_done && ctrl_q[1:0] == MODE_SINGLE)
        ctrl_q[1:0] <= MODE_IDLE;
      if (cfg_wr)  cfg_q  <= bus_wdata[15:0];
      if (mask_wr) mask_q <= bus_wdata[NSRC-1:0];
      stat_q <= (stat_q & ~stat_clr) | stat_set;
      irq    <= |(stat_q & mask_q);
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/kpd_seq.sv
module kpd_seq import kpd_pkg::*; #(
  parameter int NROW = 16,
  localparam int RW  = $clog2(NROW + 1),
  localparam int RIW = (NROW > 1) ? $clog2(NROW) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode,
  input  logic [SETTLE_W-1:0] settle,
  input  logic [GAP_W-1:0]    gap,
  input  logic [RW-1:0]       eff_rows,
  input  logic                ctl_wr,
  input  logic [1:0]          new_mode,
  output logic [NROW-1:0]     row_drive_n,
  output logic                row_we,
  output logic [RIW-1:0]      row_idx,
  output logic                scan_done,
  output logic                scan_begin
);
  kpd_seq_e        st_q;
  logic [RW-1:0]   row_q;
  logic [GAP_W-1:0] cnt_q;
  logic            in_row, settle_end, gap_end;

  assign in_row     = (st_q == SQ_SCAN) && (row_q < eff_rows);
  assign settle_end = in_row && (cnt_q == GAP_W'(settle));
  assign gap_end    = (st_q == SQ_GAP) && (cnt_q == gap);
  assign row_we     = settle_end && !ctl_wr;
  assign scan_done  = (st_q == SQ_SCAN) && !in_row && !ctl_wr;
  assign scan_begin = ctl_wr | gap_end;
  assign row_idx    = row_q[RIW-1:0];

  for (genvar r = 0; r < NROW; r++) begin : g_drv
    assign row_drive_n[r] = (mode == MODE_ANYKEY) ? 1'b0
                          : !(in_row && row_q == RW'(r));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SQ_IDLE;
      row_q <= '0;
      cnt_q <= '0;
    end else if (ctl_wr) begin
      st_q  <= new_mode[1] ? SQ_SCAN : SQ_IDLE;
      row_q <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SQ_SCAN: begin
          if (!in_row) begin
            st_q  <= (mode == MODE_CONT) ? SQ_GAP : SQ_IDLE;
            cnt_q <= '0;
          end else if (settle_end) begin
            row_q <= row_q + 1'b1;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_GAP: begin
          if (gap_end) begin
            st_q  <= SQ_SCAN;
            row_q <= '0;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          st_q <= SQ_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/kpd_store.sv
module kpd_store #(
  parameter int NROW = 16,
  parameter int NCOL = 16,
  localparam int RIW    = (NROW > 1) ? $clog2(NROW) : 1,
  localparam int NWORDS = (NROW + 1) / 2,
  localparam int WIW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            row_we,
  input  logic [RIW-1:0]  row_idx,
  input  logic [NCOL-1:0] col_in_n,
  input  logic [NCOL-1:0] col_keep,
  input  logic            scan_begin,
  input  logic [WIW-1:0]  rd_word,
  output logic            row_diff,
  output logic [31:0]     data_pair
);
  logic [NCOL-1:0] mem [NROW];
  logic [NCOL-1:0] cap;

  assign cap = col_in_n | ~col_keep;

  function automatic logic [15:0] widen(input logic [NCOL-1:0] v);
    logic [15:0] h;
    h = '1;
    h[NCOL-1:0] = v;
    return h;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NROW; r++) mem[r] <= '1;
      row_diff <= 1'b0;
    end else begin
      if (row_we) mem[row_idx] <= cap;
      if (scan_begin)
        row_diff <= 1'b0;
      else if (row_we && cap != mem[row_idx])
        row_diff <= 1'b1;
    end
  end

  always_comb begin
    int lo;
    lo = 2 * int'(rd_word);
    data_pair = '1;
    if (lo < NROW)     data_pair[15:0]  = widen(mem[lo]);
    if (lo + 1 < NROW) data_pair[31:16] = widen(mem[lo + 1]);
  end
endmodule

// File: rtl/kpd_scan_top.sv
module kpd_scan_top import kpd_pkg::*; #(
  parameter int NROW = 16,
  parameter int NCOL = 16,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NROW-1:0] row_drive_n,
  input  logic [NCOL-1:0] col_in_n,
  output logic            irq
);
  localparam int RW     = $clog2(NROW + 1);
  localparam int RIW    = (NROW > 1) ? $clog2(NROW) : 1;
  localparam int NWORDS = (NROW + 1) / 2;
  localparam int WIW    = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  logic [1:0]          mode_w;
  logic [SETTLE_W-1:0] settle_w;
  logic [GAP_W-1:0]    gap_w;
  logic [RW-1:0]       eff_rows_w;
  logic [NCOL-1:0]     col_keep_w;
  logic                ctl_wr_w, row_we_w, scan_done_w, scan_begin_w, row_diff_w;
  logic [RIW-1:0]      row_idx_w;
  logic [WIW-1:0]      rd_word_w;
  logic [31:0]         data_pair_w;
  logic [NSRC-1:0]     stat_w, mask_w;
  logic                key_seen_w;

  assign key_seen_w = (mode_w == MODE_ANYKEY) && (col_in_n != '1);

  kpd_regs #(.NROW(NROW), .NCOL(NCOL), .AW(AW)) i_regs (
    .clk, .rst, .bus_sel, .bus_wr, .bus_addr, .bus_wdata,
    .scan_done(scan_done_w), .scan_chg(row_diff_w), .key_seen(key_seen_w),
    .data_pair(data_pair_w), .mode(mode_w), .settle(settle_w), .gap(gap_w),
    .eff_rows(eff_rows_w), .col_keep(col_keep_w), .ctl_wr(ctl_wr_w),
    .rd_word(rd_word_w), .stat(stat_w), .mask(mask_w),
    .rdata(bus_rdata), .irq
  );

  kpd_seq #(.NROW(NROW)) i_seq (
    .clk, .rst, .mode(mode_w), .settle(settle_w), .gap(gap_w),
    .eff_rows(eff_rows_w), .ctl_wr(ctl_wr_w), .new_mode(bus_wdata[1:0]),
    .row_drive_n, .row_we(row_we_w), .row_idx(row_idx_w),
    .scan_done(scan_done_w), .scan_begin(scan_begin_w)
  );

  kpd_store #(.NROW(NROW), .NCOL(NCOL)) i_store (
    .clk, .rst, .row_we(row_we_w), .row_idx(row_idx_w), .col_in_n,
    .col_keep(col_keep_w), .scan_begin(scan_begin_w), .rd_word(rd_word_w),
    .row_diff(row_diff_w), .data_pair(data_pair_w)
  );
endmodule

// File: rtl/kpd_scan_chk.sv
module kpd_scan_chk #(
  parameter int NROW = 16,
  parameter int AW   = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [NROW-1:0] row_drive_n,
  input logic [1:0]      mode,
  input logic            scan_done,
  input logic            row_we,
  input logic            ctl_wr,
  input logic            key_seen,
  input logic [2:0]      stat,
  input logic [2:0]      mask,
  input logic            irq
);
  logic stat_wr;
  assign stat_wr = bus_sel && bus_wr && (bus_addr[AW-1:2] == (AW-2)'(2));

  AST_ONE_ROW_LOW: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'd1) |-> ($countones(~row_drive_n) <= 1)); // R3

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |-> (&row_drive_n)); // R4

  AST_SINGLE_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (scan_done && mode == 2'd2 && !ctl_wr) |=> (mode == 2'd0)); // R4

  AST_ANYKEY_HELD: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && key_seen) |=> stat[2]); // R6

  AST_ANYKEY_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1) |-> !row_we); // R6

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> (($past(stat) & ~stat) == 3'b000)); // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (mask == 3'b000) |=> !irq); // R10
endmodule

bind kpd_scan_top kpd_scan_chk #(.NROW(NROW), .AW(AW)) i_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .row_drive_n(row_drive_n), .mode(mode_w), .scan_done(scan_done_w),
  .row_we(row_we_w), .ctl_wr(ctl_wr_w), .key_seen(key_seen_w),
  .stat(stat_w), .mask(mask_w), .irq(irq)
);

// File: tb/test_kpd_scan_top.sv
`timescale 1ns/1ps
module test_kpd_scan_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] row_drive_n, col_in_n;
  logic        irq;

  always #5 clk = ~clk;

  kpd_scan_top i_kpd_scan_top (
    .clk, .rst, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .row_drive_n, .col_in_n, .irq
  );

  // key matrix, 1 = pressed
  logic [15:0] keys [16];
  initial for (int r = 0; r < 16; r++) keys[r] = '0;

  function automatic logic [15:0] cols_for(input logic [15:0] drv);
    logic [15:0] c;
    c = '1;
    for (int r = 0; r < 16; r++) if (!drv[r]) c &= ~keys[r];
    return c;
  endfunction

  always_comb col_in_n = cols_for(row_drive_n);

  int    vecs = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %h expected %h", req, cyc, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_ctrl;
  logic [15:0] m_cfg;
  logic [2:0]  m_stat, m_mask;
  logic        m_irq, m_diff, m_rd_pend;
  logic [15:0] m_data [16];
  logic [31:0] m_rdata;
  int          m_state, m_row, m_cnt; // state: 0 idle, 1 scanning, 2 gap

  function automatic int eff_rows();
    return (m_cfg[7:0] > 16) ? 16 : int'(m_cfg[7:0]);
  endfunction

  function automatic logic [15:0] model_drive();
    if (m_ctrl[1:0] == 2'd1) return 16'h0000;
    if (m_state == 1 && m_row < eff_rows()) return ~(16'h1 << m_row);
    return 16'hffff;
  endfunction

  function automatic logic [31:0] model_read(input int wa);
    case (wa)
      0: return m_ctrl;
      1: return {16'h0, m_cfg};
      2: return {29'h0, m_stat};
      3: return {29'h0, m_mask};
      default:
        if (wa >= 4 && wa < 12) return {m_data[2*(wa-4)+1], m_data[2*(wa-4)]};
        else return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_ctrl = '0; m_cfg = 16'h1010; m_stat = '0; m_mask = '0; m_irq = 1'b0;
      m_diff = 1'b0; m_rd_pend = 1'b0; m_rdata = '0;
      m_state = 0; m_row = 0; m_cnt = 0;
      for (int r = 0; r < 16; r++) m_data[r] = 16'hffff;
    end else begin
      logic [15:0] drv, col, keep, v;
      logic        pressed, done, chg, ctl_w;
      int          wa, er, ec;
      drv = model_drive();
      col = cols_for(drv);
      pressed = (col != 16'hffff);
      er = eff_rows();
      ec = (m_cfg[15:8] > 16) ? 16 : int'(m_cfg[15:8]);
      keep = '0;
      for (int c = 0; c < 16; c++) if (c < ec) keep[c] = 1'b1;
      wa = int'(bus_addr[5:2]);
      ctl_w = bus_sel && bus_wr && wa == 0;
      if (bus_sel && !bus_wr) begin m_rdata = model_read(wa); m_rd_pend = 1'b1; end
      m_irq = |(m_stat & m_mask);
      done = 1'b0; chg = 1'b0;
      if (ctl_w) begin
        m_state = bus_wdata[1] ? 1 : 0; m_row = 0; m_cnt = 0; m_diff = 1'b0;
      end else if (m_state == 1) begin
        if (m_row >= er) begin
          done = 1'b1; chg = m_diff;
          m_state = (m_ctrl[1:0] == 2'd3) ? 2 : 0; m_cnt = 0;
        end else if (m_cnt == int'(m_ctrl[15:2])) begin
          v = col | ~keep;
          if (v != m_data[m_row]) m_diff = 1'b1;
          m_data[m_row] = v; m_row++; m_cnt = 0;
        end else m_cnt++;
      end else if (m_state == 2) begin
        if (m_cnt == int'(m_ctrl[31:16])) begin
          m_state = 1; m_row = 0; m_cnt = 0; m_diff = 1'b0;
        end else m_cnt++;
      end
      m_stat = (m_stat & ~((bus_sel && bus_wr && wa == 2) ? bus_wdata[2:0] : 3'b0))
             | {m_ctrl[1:0] == 2'd1 && pressed, chg, done};
      if (ctl_w) m_ctrl = bus_wdata;
      else if (done && m_ctrl[1:0] == 2'd2) m_ctrl[1:0] = 2'd0;
      if (bus_sel && bus_wr && wa == 1) m_cfg = bus_wdata[15:0];
      if (bus_sel && bus_wr && wa == 3) m_mask = bus_wdata[2:0];
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk({cur_req, " rows"}, {16'h0, row_drive_n}, {16'h0, model_drive()});
      chk({cur_req, " irq"}, {31'h0, irq}, {31'h0, m_irq});
      if (m_rd_pend) begin
        chk({cur_req, " read"}, bus_rdata, m_rdata);
        m_rd_pend = 1'b0;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_all();
    rd(6'h00); rd(6'h04); rd(6'h08); rd(6'h0C);
    for (int k = 0; k < 8; k++) rd(6'(16 + 4*k));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired: got hung run, expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    cur_req = "R1"; idle(2); read_all();
    // R2 control fields read back, mode 0
    cur_req = "R2"; wr(6'h00, {16'd3, 14'd2, 2'd0}); rd(6'h00); idle(2);
    // R3 R4 R11 single scan with a pattern
    keys[0] = 16'h0001; keys[5] = 16'h8100; keys[15] = 16'h4002; keys[8] = 16'h0010;
    cur_req = "R3"; wr(6'h00, {16'd3, 14'd2, 2'd2}); idle(20);
    cur_req = "R4"; idle(40); rd(6'h00);
    cur_req = "R11"; read_all();
    // R9 change flag then W1C, set wins check via re-scan
    cur_req = "R9"; wr(6'h08, 32'h1); rd(6'h08); wr(6'h08, 32'h2); rd(6'h08);
    wr(6'h00, {16'd0, 14'd0, 2'd2}); idle(20); rd(6'h08); wr(6'h08, 32'h7); rd(6'h08);
    // R8 column truncation
    cur_req = "R8"; wr(6'h04, 32'h0510); keys[3] = 16'h00ff;
    wr(6'h00, {16'd0, 14'd1, 2'd2}); idle(40); read_all();
    // R7 row truncation
    cur_req = "R7"; wr(6'h04, 32'h1003); keys[1] = 16'h0f0f; keys[5] = 16'h0000;
    wr(6'h00, {16'd0, 14'd1, 2'd2}); idle(15); read_all();
    wr(6'h04, 32'h10ff); wr(6'h00, {16'd0, 14'd0, 2'd2}); idle(25); read_all();
    // R10 mask and interrupt
    cur_req = "R10"; wr(6'h08, 32'h7); wr(6'h0C, 32'h1);
    wr(6'h00, {16'd0, 14'd0, 2'd2}); idle(25); wr(6'h08, 32'h1); idle(3);
    wr(6'h0C, 32'h2); keys[9] = 16'h1000; wr(6'h00, {16'd0, 14'd0, 2'd2}); idle(25);
    wr(6'h0C, 32'h0); idle(3); wr(6'h08, 32'h7);
    // R5 continuous scanning with gap, keys change mid-run
    cur_req = "R5"; wr(6'h0C, 32'h3); wr(6'h00, {16'd4, 14'd1, 2'd3}); idle(60);
    keys[2] = 16'h0200; idle(80); read_all();
    // R12 restart by control write mid-scan
    cur_req = "R12"; wr(6'h00, {16'd4, 14'd3, 2'd3}); idle(9);
    wr(6'h00, {16'd4, 14'd3, 2'd3}); idle(5); wr(6'h00, {16'd2, 14'd0, 2'd0}); idle(3);
    rd(6'h08); wr(6'h08, 32'h7);
    // R6 any-key detection: data untouched, bit 2 holds while pressed
    cur_req = "R6"; wr(6'h0C, 32'h4); wr(6'h00, 32'h1); idle(3); rd(6'h08);
    wr(6'h08, 32'h4); rd(6'h08);
    for (int r = 0; r < 16; r++) keys[r] = '0;
    idle(2); wr(6'h08, 32'h4); rd(6'h08); idle(2); read_all();
    wr(6'h00, 32'h0); idle(3);
    summary();
  end
endmodule